// File: doc/BRIEF.md
# Capture-Compare Timer with Edge Capture

This block is a free-running up-counter with one compare register and two capture registers. It is steered by an 8-bit mode register that is written as a whole. The counter advances on one of four count sources: rising edges of an external input pin, or one of three prescaler enable ticks (every cycle, every 4th cycle, every 16th cycle). The prescaler ticks are generated outside the block. On a compare match the counter can either be cleared or left to run on, and a one-cycle match pulse is driven out.

Edges from the external pin or from a companion timer's output latch the counter value into the capture registers. Rising edges go to capture register 0 and falling edges to capture register 1, depending on the capture mode. A software strobe folded into the mode-register write can also copy the counter into capture register 0. A one-cycle interrupt request follows each rising edge of the pin in the pin-based capture modes.

Both asynchronous inputs pass through a synchronizer. Each then feeds a two-state edge tracker, with states `ES_LOW` and `ES_HIGH`. The transition `ES_LOW→ES_HIGH` on a synchronized high produces a rise event. The transition `ES_HIGH→ES_LOW` on a synchronized low produces a fall event. In every other case the tracker stays in its state and produces no event.

Mode register layout: bits [1:0] count source, bit [2] clear-on-match, bits [4:3] capture mode, bit [5] software-capture strobe (active when written 0), bits [7:6] reserved and must be written 0.

Top module: `ccap_timer`

## Requirements
- R1: Count source field mode[1:0]: 00 counts synchronized rising edges of `pin_in`, 01 counts `tick_div1`, 10 counts `tick_div4`, 11 counts `tick_div16`; exactly one increment per selected event.
- R2: The counter is CNT_W bits (16 by default), holds between events, and wraps from all-ones to 0; with mode[2]=0 it runs past the compare value unhindered.
- R3: With mode[2]=1, a count event that finds the counter equal to the compare register loads 0 instead of incrementing.
- R4: `match` is high for one cycle each time the counter arrives at the compare value, in the cycle the new value is visible, and only when the counter equals the compare register.
- R5: Capture mode mode[4:3]=01 copies the counter into `cap0` on a rising pin edge; falling pin edges and all `peer_in` edges leave both capture registers unchanged.
- R6: Capture mode 10 copies the counter into `cap0` on a rising pin edge and into `cap1` on a falling pin edge.
- R7: Capture mode 11 copies the counter into `cap0` on a rising `peer_in` edge and into `cap1` on a falling `peer_in` edge; pin edges capture nothing.
- R8: Capture mode 00 captures nothing from either input.
- R9: A mode write with bit 5 at 0 copies the counter value present in the write cycle into `cap0`; a write with bit 5 at 1 does not; if it coincides with a hardware capture into `cap0`, the software capture takes precedence.
- R10: `irq` pulses for one cycle after each rising pin edge, only in capture modes 01 and 10.
- R11: An input change applied before clock edge k is registered by two flip-flops; the capture takes the counter value visible between edges k+1 and k+2, and `irq` is high after edge k+2; a level held for many cycles yields exactly one event.
- R12: After reset the counter, compare, capture registers, `match` and `irq` are 0, count source is the pin, clear-on-match and capture are off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_div1 | input | 1 | Prescaler enable, every cycle |
| tick_div4 | input | 1 | Prescaler enable, one in four cycles |
| tick_div16 | input | 1 | Prescaler enable, one in sixteen cycles |
| pin_in | input | 1 | External capture/count pin, asynchronous |
| peer_in | input | 1 | Companion timer output, asynchronous |
| mode_we | input | 1 | Mode register write strobe |
| mode_wdata | input | 8 | Mode register write data |
| cmp_we | input | 1 | Compare register write strobe |
| cmp_wdata | input | CNT_W | Compare register write data |
| count | output | CNT_W | Current counter value |
| cap0 | output | CNT_W | Capture register 0 |
| cap1 | output | CNT_W | Capture register 1 |
| match | output | 1 | Compare match pulse |
| irq | output | 1 | Capture-input interrupt request |

## Verification
The bench builds the block with the default CNT_W of 16 and two synchronizer stages. At these values the all-ones-to-zero wrap can be reached by running the every-cycle tick for about 65,000 cycles, which stays within the run length. The two-stage latency also gives a fixed capture cycle, so the bench can predict each captured value from the counter it reads two cycles after driving an edge.

// File: rtl/ccap_pkg.sv
package ccap_pkg;

    typedef enum logic [1:0] {
        CS_PIN   = 2'b00,
        CS_DIV1  = 2'b01,
        CS_DIV4  = 2'b10,
        CS_DIV16 = 2'b11
    } clk_sel_e;

    typedef enum logic [1:0] {
        CM_OFF       = 2'b00,
        CM_PIN_RISE  = 2'b01,
        CM_PIN_BOTH  = 2'b10,
        CM_PEER_BOTH = 2'b11
    } cap_mode_e;

    typedef enum logic {
        ES_LOW  = 1'b0,
        ES_HIGH = 1'b1
    } edge_state_e;

    localparam int MODE_W       = 8;
    localparam int MB_CLK_LO    = 0;
    localparam int MB_CLR       = 2;
    localparam int MB_CAP_LO    = 3;
    localparam int MB_SWCAP_N   = 5;
    localparam int MB_RSVD_LO   = 6;

endpackage

// File: rtl/ccap_edge_fsm.sv
module ccap_edge_fsm
    import ccap_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_in,
    output logic rise,
    output logic fall
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   lvl;
    edge_state_e            state_q;
    edge_state_e            state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], raw_in};
        end
    end

    assign lvl = sync_q[SYNC_STAGES-1];

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ES_LOW;
        end else begin
            state_q <= state_nx;
        end
    end

    // Next state and outputs
    always_comb begin
        state_nx = state_q;
        rise     = 1'b0;
        fall     = 1'b0;
        unique case (state_q)
            ES_LOW: begin
                if (lvl) begin
                    state_nx = ES_HIGH;
                    rise     = 1'b1;
                end
            end
            ES_HIGH: begin
                if (!lvl) begin
                    state_nx = ES_LOW;
                    fall     = 1'b1;
                end
            end
            default: state_nx = ES_LOW;
        endcase
    end

    AST_RISE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise); // R11
    AST_FALL_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall); // R11

endmodule

// File: rtl/ccap_counter.sv
module ccap_counter
    import ccap_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  clk_sel_e         clk_sel,
    input  logic             clr_en,
    input  logic             pin_tick,
    input  logic             tick_div1,
    input  logic             tick_div4,
    input  logic             tick_div16,
    input  logic             cmp_we,
    input  logic [CNT_W-1:0] cmp_wdata,
    output logic [CNT_W-1:0] cnt,
    output logic             match
);

    logic [CNT_W-1:0] cmp_q;
    logic [CNT_W-1:0] cmp_nx;
    logic [CNT_W-1:0] cnt_nx;
    logic             adv;

    always_comb begin
        adv = 1'b0;
        unique case (clk_sel)
            CS_PIN:   adv = pin_tick;
            CS_DIV1:  adv = tick_div1;
            CS_DIV4:  adv = tick_div4;
            CS_DIV16: adv = tick_div16;
            default:  adv = 1'b0;
        endcase
    end

    assign cmp_nx = cmp_we ? cmp_wdata : cmp_q;

    always_comb begin
        cnt_nx = cnt;
        if (adv) begin
            if (clr_en && (cnt == cmp_q)) begin
                cnt_nx = '0;
            end else begin
                cnt_nx = cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            cmp_q <= '0;
            match <= 1'b0;
        end else begin
            cnt   <= cnt_nx;
            cmp_q <= cmp_nx;
            match <= adv && (cnt_nx == cmp_nx);
        end
    end

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(cnt)); // R2
    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && clr_en && (cnt == cmp_q)) |=> (cnt == '0)); // R3
    AST_MATCH_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
        match |-> (cnt == cmp_q)); // R4

endmodule

// File: rtl/ccap_capture.sv
module ccap_capture
    import ccap_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  cap_mode_e        cap_mode,
    input  logic             pin_rise,
    input  logic             pin_fall,
    input  logic             peer_rise,
    input  logic             peer_fall,
    input  logic             sw_cap,
    input  logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] cap0,
    output logic [CNT_W-1:0] cap1
);

    logic hw0;
    logic hw1;

    always_comb begin
        hw0 = 1'b0;
        hw1 = 1'b0;
        unique case (cap_mode)
            CM_OFF: begin
                hw0 = 1'b0;
                hw1 = 1'b0;
            end
            CM_PIN_RISE: begin
                hw0 = pin_rise;
            end
            CM_PIN_BOTH: begin
                hw0 = pin_rise;
                hw1 = pin_fall;
            end
            CM_PEER_BOTH: begin
                hw0 = peer_rise;
                hw1 = peer_fall;
            end
            default: begin
                hw0 = 1'b0;
                hw1 = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap0 <= '0;
            cap1 <= '0;
        end else begin
            // Software strobe is served first on register 0
            if (sw_cap) begin
                cap0 <= cnt;
            end else if (hw0) begin
                cap0 <= cnt;
            end
            if (hw1) begin
                cap1 <= cnt;
            end
        end
    end

    AST_CAP1_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ((cap_mode == CM_OFF) || (cap_mode == CM_PIN_RISE)) |=> $stable(cap1)); // R5
    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ((cap_mode == CM_OFF) && !sw_cap) |=> $stable(cap0)); // R8
    AST_SW_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        sw_cap |=> (cap0 == $past(cnt))); // R9

endmodule

// File: rtl/ccap_timer.sv
module ccap_timer
    import ccap_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_div1,
    input  logic             tick_div4,
    input  logic             tick_div16,
    input  logic             pin_in,
    input  logic             peer_in,
    input  logic             mode_we,
    input  logic [7:0]       mode_wdata,
    input  logic             cmp_we,
    input  logic [CNT_W-1:0] cmp_wdata,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] cap0,
    output logic [CNT_W-1:0] cap1,
    output logic             match,
    output logic             irq
);

    localparam int N_SRC    = 2;
    localparam int SRC_PIN  = 0;
    localparam int SRC_PEER = 1;

    logic [N_SRC-1:0] src_raw;
    logic [N_SRC-1:0] src_rise;
    logic [N_SRC-1:0] src_fall;

    clk_sel_e  clk_sel_q;
    logic      clr_en_q;
    cap_mode_e cap_mode_q;
    logic      sw_cap;
    logic      pin_irq_mode;

    assign src_raw[SRC_PIN]  = pin_in;
    assign src_raw[SRC_PEER] = peer_in;

    for (genvar g = 0; g < N_SRC; g++) begin : g_edge
        ccap_edge_fsm #(
            .SYNC_STAGES (SYNC_STAGES)
        ) i_edge (
            .clk    (clk),
            .rst_n  (rst_n),
            .raw_in (src_raw[g]),
            .rise   (src_rise[g]),
            .fall   (src_fall[g])
        );
    end

    // Mode register, written whole
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_sel_q  <= CS_PIN;
            clr_en_q   <= 1'b0;
            cap_mode_q <= CM_OFF;
        end else if (mode_we) begin
            clk_sel_q  <= clk_sel_e'(mode_wdata[MB_CLK_LO +: 2]);
            clr_en_q   <= mode_wdata[MB_CLR];
            cap_mode_q <= cap_mode_e'(mode_wdata[MB_CAP_LO +: 2]);
        end
    end

    assign sw_cap       = mode_we && !mode_wdata[MB_SWCAP_N];
    assign pin_irq_mode = (cap_mode_q == CM_PIN_RISE) || (cap_mode_q == CM_PIN_BOTH);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq <= 1'b0;
        end else begin
            irq <= src_rise[SRC_PIN] && pin_irq_mode;
        end
    end

    ccap_counter #(
        .CNT_W (CNT_W)
    ) i_counter (
        .clk        (clk),
        .rst_n      (rst_n),
        .clk_sel    (clk_sel_q),
        .clr_en     (clr_en_q),
        .pin_tick   (src_rise[SRC_PIN]),
        .tick_div1  (tick_div1),
        .tick_div4  (tick_div4),
        .tick_div16 (tick_div16),
        .cmp_we     (cmp_we),
        .cmp_wdata  (cmp_wdata),
        .cnt        (count),
        .match      (match)
    );

    ccap_capture #(
        .CNT_W (CNT_W)
    ) i_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_mode  (cap_mode_q),
        .pin_rise  (src_rise[SRC_PIN]),
        .pin_fall  (src_fall[SRC_PIN]),
        .peer_rise (src_rise[SRC_PEER]),
        .peer_fall (src_fall[SRC_PEER]),
        .sw_cap    (sw_cap),
        .cnt       (count),
        .cap0      (cap0),
        .cap1      (cap1)
    );

    AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (src_rise[SRC_PIN] && pin_irq_mode) |=> irq); // R10
    AST_IRQ_ONLY_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        !src_rise[SRC_PIN] |=> !irq); // R10
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        mode_we |-> (mode_wdata[MB_RSVD_LO +: 2] == 2'b00)); // R12

endmodule

// File: tb/test_ccap_timer.sv
module test_ccap_timer;

    localparam int CNT_W = 16;
    localparam int WATCHDOG = 190000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             tick_div1 = 1'b1;
    logic             tick_div4;
    logic             tick_div16;
    logic             pin_in = 1'b0;
    logic             peer_in = 1'b0;
    logic             mode_we = 1'b0;
    logic [7:0]       mode_wdata = '0;
    logic             cmp_we = 1'b0;
    logic [CNT_W-1:0] cmp_wdata = '0;
    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] cap0;
    logic [CNT_W-1:0] cap1;
    logic             match;
    logic             irq;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    int tc = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    assign tick_div4  = (tc % 4) == 0;
    assign tick_div16 = (tc % 16) == 0;

    ccap_timer #(.CNT_W(CNT_W), .SYNC_STAGES(2)) i_ccap_timer (
        .clk(clk), .rst_n(rst_n), .tick_div1(tick_div1), .tick_div4(tick_div4),
        .tick_div16(tick_div16), .pin_in(pin_in), .peer_in(peer_in),
        .mode_we(mode_we), .mode_wdata(mode_wdata), .cmp_we(cmp_we),
        .cmp_wdata(cmp_wdata), .count(count), .cap0(cap0), .cap1(cap1),
        .match(match), .irq(irq)
    );

    initial forever begin
        @(negedge clk);
        tc++;
        cycles++;
        if (cycles > WATCHDOG && !done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: run hung, actual %0d cycles expected < %0d", cycles, WATCHDOG);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        pin_in = 1'b0;
        peer_in = 1'b0;
        mode_we = 1'b0;
        cmp_we = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic write_mode(input logic [7:0] v);
        @(negedge clk);
        mode_we = 1'b1;
        mode_wdata = v;
        @(negedge clk);
        mode_we = 1'b0;
    endtask

    task automatic write_cmp(input logic [CNT_W-1:0] v);
        @(negedge clk);
        cmp_we = 1'b1;
        cmp_wdata = v;
        @(negedge clk);
        cmp_we = 1'b0;
    endtask

    // Drive an edge, return the counter value the capture should take
    task automatic drive_edge(input bit peer, input bit lvl, output logic [CNT_W-1:0] c);
        if (peer) peer_in = lvl; else pin_in = lvl;
        @(negedge clk);
        @(negedge clk);
        c = count;
        @(negedge clk);
    endtask

    function automatic logic [7:0] mval(input logic [1:0] cs, input bit clr, input logic [1:0] cm);
        return {2'b00, 1'b1, cm, clr, cs};
    endfunction

    task automatic t_reset();
        do_reset();
        check(count == 0, "R12 count", count, 0);
        check(cap0 == 0 && cap1 == 0, "R12 caps", {cap1, cap0}, 0);
        check(match == 0 && irq == 0, "R12 match/irq", {match, irq}, 0);
        repeat (20) @(negedge clk);
        check(count == 0, "R12 pin source idle", count, 0);
        pin_in = 1'b1;
        repeat (3) @(negedge clk);
        check(cap0 == 0 && irq == 0, "R12 capture off", cap0, 0);
        pin_in = 1'b0;
        repeat (3) @(negedge clk);
        check(count == 1, "R12 pin clock default", count, 1);
    endtask

    task automatic t_clock_select();
        logic [CNT_W-1:0] c0;
        do_reset();
        write_mode(mval(2'b01, 0, 2'b00));
        c0 = count;
        repeat (64) @(negedge clk);
        check(CNT_W'(count - c0) == 64, "R1 div1", count - c0, 64);
        write_mode(mval(2'b10, 0, 2'b00));
        c0 = count;
        repeat (64) @(negedge clk);
        check(CNT_W'(count - c0) == 16, "R1 div4", count - c0, 16);
        write_mode(mval(2'b11, 0, 2'b00));
        c0 = count;
        repeat (64) @(negedge clk);
        check(CNT_W'(count - c0) == 4, "R1 div16", count - c0, 4);
        write_mode(mval(2'b00, 0, 2'b00));
        c0 = count;
        for (int i = 0; i < 5; i++) begin
            pin_in = 1'b1;
            repeat (10) @(negedge clk);
            pin_in = 1'b0;
            repeat (3) @(negedge clk);
        end
        repeat (4) @(negedge clk);
        check(CNT_W'(count - c0) == 5, "R1 R11 pin edges one count each", count - c0, 5);
    endtask

    task automatic t_clear();
        bit bad_range = 0;
        bit bad_match = 0;
        int nmatch = 0;
        do_reset();
        write_cmp(9);
        write_mode(mval(2'b01, 1, 2'b00));
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (count > 9) bad_range = 1;
            if (match != (count == 9)) bad_match = 1;
            if (match) nmatch++;
        end
        check(!bad_range, "R3 counter bounded by compare", count, 9);
        check(!bad_match, "R4 match only on arrival at compare", match, count == 9);
        check(nmatch == 10, "R4 match pulses per period", nmatch, 10);
    endtask

    task automatic t_wrap();
        bit passed = 0;
        int guard = 0;
        do_reset();
        write_cmp(5);
        write_mode(mval(2'b01, 0, 2'b00));
        while (count != 16'hFFFE && guard < 70000) begin
            @(negedge clk);
            if (count == 6) passed = 1;
            guard++;
        end
        check(passed, "R2 free run passes compare", passed, 1);
        @(negedge clk);
        check(count == 16'hFFFF, "R2 top value", count, 16'hFFFF);
        @(negedge clk);
        check(count == 0, "R2 wrap to zero", count, 0);
    endtask

    task automatic t_mode_pin_rise();
        logic [CNT_W-1:0] c;
        logic [CNT_W-1:0] keep;
        do_reset();
        write_mode(mval(2'b01, 0, 2'b01));
        repeat (5) @(negedge clk);
        drive_edge(0, 1, c);
        check(cap0 == c, "R5 R11 rise capture", cap0, c);
        check(irq == 1, "R10 R11 irq after rise", irq, 1);
        @(negedge clk);
        check(irq == 0, "R10 irq one cycle", irq, 0);
        repeat (10) @(negedge clk);
        check(cap0 == c, "R11 held level no recapture", cap0, c);
        keep = cap0;
        drive_edge(0, 0, c);
        check(cap1 == 0 && cap0 == keep, "R5 fall ignored", {cap1, cap0}, {16'h0, keep});
        check(irq == 0, "R10 no irq on fall", irq, 0);
        drive_edge(1, 1, c);
        check(cap0 == keep, "R5 peer ignored", cap0, keep);
        drive_edge(1, 0, c);
    endtask

    task automatic t_mode_pin_both();
        logic [CNT_W-1:0] c;
        do_reset();
        write_mode(mval(2'b01, 0, 2'b10));
        repeat (7) @(negedge clk);
        drive_edge(0, 1, c);
        check(cap0 == c, "R6 rise to cap0", cap0, c);
        check(irq == 1, "R10 irq mode 10", irq, 1);
        repeat (6) @(negedge clk);
        drive_edge(0, 0, c);
        check(cap1 == c, "R6 fall to cap1", cap1, c);
        check(irq == 0, "R10 no irq on fall", irq, 0);
    endtask

    task automatic t_mode_peer();
        logic [CNT_W-1:0] c;
        logic [CNT_W-1:0] k0;
        logic [CNT_W-1:0] k1;
        do_reset();
        write_mode(mval(2'b01, 0, 2'b11));
        repeat (3) @(negedge clk);
        k0 = cap0;
        k1 = cap1;
        drive_edge(0, 1, c);
        check(cap0 == k0 && irq == 0, "R7 R10 pin rise ignored", {irq, cap0}, {1'b0, k0});
        drive_edge(0, 0, c);
        check(cap1 == k1, "R7 pin fall ignored", cap1, k1);
        drive_edge(1, 1, c);
        check(cap0 == c, "R7 peer rise to cap0", cap0, c);
        check(irq == 0, "R10 no irq on peer", irq, 0);
        repeat (4) @(negedge clk);
        drive_edge(1, 0, c);
        check(cap1 == c, "R7 peer fall to cap1", cap1, c);
        write_mode(mval(2'b01, 0, 2'b00));
        k0 = cap0;
        k1 = cap1;
        drive_edge(0, 1, c);
        drive_edge(1, 1, c);
        drive_edge(0, 0, c);
        drive_edge(1, 0, c);
        check(cap0 == k0 && cap1 == k1, "R8 capture disabled", {cap1, cap0}, {k1, k0});
    endtask

    task automatic t_soft_capture();
        logic [CNT_W-1:0] c;
        logic [CNT_W-1:0] k0;
        do_reset();
        write_mode(mval(2'b01, 0, 2'b01));
        repeat (9) @(negedge clk);
        @(negedge clk);
        c = count;
        mode_we = 1'b1;
        mode_wdata = mval(2'b01, 0, 2'b01) & 8'hDF;
        @(negedge clk);
        mode_we = 1'b0;
        check(cap0 == c, "R9 software capture", cap0, c);
        k0 = cap0;
        write_mode(mval(2'b01, 0, 2'b01));
        repeat (3) @(negedge clk);
        check(cap0 == k0, "R9 strobe bit 1 no capture", cap0, k0);
        // Hardware rise and software strobe on the same edge
        pin_in = 1'b1;
        @(negedge clk);
        @(negedge clk);
        c = count;
        mode_we = 1'b1;
        mode_wdata = mval(2'b01, 0, 2'b01) & 8'hDF;
        @(negedge clk);
        mode_we = 1'b0;
        check(cap0 == c, "R9 coincident captures", cap0, c);
        pin_in = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        t_reset();
        t_clock_select();
        t_clear();
        t_wrap();
        t_mode_pin_rise();
        t_mode_pin_both();
        t_mode_peer();
        t_soft_capture();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule